// File: doc/BRIEF.md
# Bus Address Cost and Battery-RAM Decoder

This block sits beside a CPU bus and classifies each 24-bit address, made of an 8-bit bank and a 16-bit offset. For every address it reports how many master clocks the access costs. It flags whether the access falls in the ROM class. It also tells whether the address lands in the battery-backed RAM window and, if so, which masked offset inside that RAM it touches. The cost is worked out from a few bit tests on the address, with no range table. The RAM offset follows one of two cartridge folding styles, chosen by an input pin.

Each byte access is signalled with a one-cycle strobe. The block adds the access cost to a running cycle counter, except while a DMA transfer owns the bus. When the counter reaches a programmed threshold, an event flag is raised and stays up until the threshold is advanced. A RAM write is only allowed out when RAM is fitted, meaning the size mask is non-zero. Every allowed write sets a sticky modified flag, which software clears with a dedicated input.

Top module: `bus_region_timer`

## Requirements
- R1: When address bit 22 or bit 15 is set, rom_class is 1. In that case the cost is 6 when bit 23 and fast_rom_en are both 1, and 8 otherwise.
- R2: When the address is not ROM class and bit 14 of (address + 0x6000), taken modulo 2^24, is set, the cost is 8.
- R3: When neither rule above applies, the cost is 6 if (address - 0x4000) has any bit set within 0x7E00, and 12 otherwise.
- R4: With ram_style = 0 (low style), the RAM window is: bank bits 6:4 equal to 111, bank bits 3:1 not equal to 111, and offset bit 15 clear. In this style ram_offset = ({bank, offset[14:0]}) & ram_mask.
- R5: With ram_style = 1 (high style), the RAM window is: bank bits 6:5 equal to 01 and offset bits 15:13 equal to 011. In this style ram_offset = ((offset & 0x7FFF) - 0x6000 + (address bits 19:16 shifted left by 13)) & ram_mask.
- R6: ram_we is 1 only for a strobed write that hits the RAM window while ram_mask is non-zero. A write with ram_mask zero, a read, or an address outside the window leaves ram_we at 0 and does not change ram_dirty.
- R7: ram_dirty rises on the clock edge after an accepted write. It holds until the edge on which dirty_clr is 1 with no accepted write in the same cycle.
- R8: On every strobed access with dma_active = 0, cycle_count grows by the access cost on that edge. While dma_active = 1, cycle_count holds.
- R9: event_due rises on the edge after cycle_count is at or above next_event. It returns to 0 on the edge where event_adv is 1, because clearing has priority.
- R10: After reset, cycle_count, ram_dirty and event_due are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One byte access this cycle |
| acc_write | input | 1 | The access is a write |
| acc_addr | input | 24 | Bank and offset of the access |
| dma_active | input | 1 | A DMA transfer owns the bus |
| fast_rom_en | input | 1 | Selects the fast cost for upper-half ROM |
| ram_style | input | 1 | 0 low folding style, 1 high folding style |
| ram_mask | input | RAM_AW | RAM size mask, zero means no RAM |
| next_event | input | ACC_W | Event threshold for the cycle counter |
| event_adv | input | 1 | Threshold advanced, clears event_due |
| dirty_clr | input | 1 | Clears the modified flag |
| acc_cost | output | 4 | Access cost in master clocks |
| rom_class | output | 1 | Address is in the ROM class |
| ram_hit | output | 1 | Address is in the battery-RAM window |
| ram_offset | output | RAM_AW | Masked RAM offset |
| ram_we | output | 1 | Accepted RAM write strobe |
| ram_dirty | output | 1 | Sticky RAM-modified flag |
| cycle_count | output | ACC_W | Running cycle counter |
| event_due | output | 1 | Counter has reached the threshold |

## Verification
The hardest case to reach is the timing of the event flag. It depends on a counter value built up over several accesses, on a DMA window that must freeze that counter, and on the exact cycle when the threshold is advanced. The stimulus first builds a known count from accesses whose cost is known. It then holds the strobe high during a DMA window. After that it moves the threshold below the count and pulses event_adv, so that the clear and the following set can be seen on back-to-back edges.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int COST_W = 4;
  localparam logic [COST_W-1:0] COST_FAST  = 4'd6;
  localparam logic [COST_W-1:0] COST_SLOW  = 4'd8;
  localparam logic [COST_W-1:0] COST_XSLOW = 4'd12;

  typedef enum logic {
    FOLD_LOW  = 1'b0,
    FOLD_HIGH = 1'b1
  } fold_style_e;
endpackage

// File: rtl/brt_cost_decode.sv
module brt_cost_decode
  import brt_pkg::*;
(
  input  logic [23:0]       addr,
  input  logic              fast_rom_en,
  output logic [COST_W-1:0] cost,
  output logic              rom_class
);
  logic [23:0] plus_off;
  logic [23:0] minus_off;

  always_comb begin
    plus_off  = addr + 24'h006000;
    minus_off = addr - 24'h004000;
    rom_class = addr[22] | addr[15];
    if (rom_class) begin
      cost = (addr[23] && fast_rom_en) ? COST_FAST : COST_SLOW;
    end else if (plus_off[14]) begin
      cost = COST_SLOW;
    end else if ((minus_off & 24'h007E00) != 24'h0) begin
      cost = COST_FAST;
    end else begin
      cost = COST_XSLOW;
    end
  end
endmodule

// File: rtl/brt_ram_xlate.sv
module brt_ram_xlate
  import brt_pkg::*;
#(
  parameter int RAM_AW = 20
) (
  input  logic [23:0]       addr,
  input  logic              style,
  input  logic [RAM_AW-1:0] mask,
  output logic [RAM_AW-1:0] offset,
  output logic              hit
);
  logic [7:0]  bank;
  logic [15:0] off;
  logic [23:0] low_full;
  logic [23:0] high_full;
  logic [23:0] pick;
  logic        low_hit;
  logic        high_hit;

  always_comb begin
    bank      = addr[23:16];
    off       = addr[15:0];
    low_full  = {1'b0, bank, off[14:0]};
    high_full = {9'b0, off[14:0]} - 24'h006000 + {7'b0, addr[19:16], 13'b0};
    low_hit   = (bank[6:4] == 3'b111) && (bank[3:1] != 3'b111) && !off[15];
    high_hit  = (bank[6:5] == 2'b01) && (off[15:13] == 3'b011);
    pick      = (fold_style_e'(style) == FOLD_HIGH) ? high_full : low_full;
    hit       = (fold_style_e'(style) == FOLD_HIGH) ? high_hit : low_hit;
    offset    = pick[RAM_AW-1:0] & mask;
  end
endmodule

// File: rtl/brt_cycle_accum.sv
module brt_cycle_accum
  import brt_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic [COST_W-1:0] cost,
  input  logic [ACC_W-1:0]  threshold,
  input  logic              thr_adv,
  output logic [ACC_W-1:0]  count,
  output logic              due
);
  logic [ACC_W-1:0] count_d;
  logic             due_d;

  always_comb begin
    count_d = count;
    if (add_en) begin
      count_d = count + ACC_W'(cost);
    end
    due_d = due;
    if (thr_adv) begin
      due_d = 1'b0;
    end else if (count >= threshold) begin
      due_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      due   <= 1'b0;
    end else begin
      count <= count_d;
      due   <= due_d;
    end
  end
endmodule

// File: rtl/bus_region_timer.sv
module bus_region_timer
  import brt_pkg::*;
#(
  parameter int RAM_AW = 20,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [23:0]       acc_addr,
  input  logic              dma_active,
  input  logic              fast_rom_en,
  input  logic              ram_style,
  input  logic [RAM_AW-1:0] ram_mask,
  input  logic [ACC_W-1:0]  next_event,
  input  logic              event_adv,
  input  logic              dirty_clr,
  output logic [3:0]        acc_cost,
  output logic              rom_class,
  output logic              ram_hit,
  output logic [RAM_AW-1:0] ram_offset,
  output logic              ram_we,
  output logic              ram_dirty,
  output logic [ACC_W-1:0]  cycle_count,
  output logic              event_due
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       add_en;
  logic       dirty_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  brt_cost_decode u_cost (
    .addr        (acc_addr),
    .fast_rom_en (fast_rom_en),
    .cost        (acc_cost),
    .rom_class   (rom_class)
  );

  brt_ram_xlate #(.RAM_AW(RAM_AW)) u_xlate (
    .addr   (acc_addr),
    .style  (ram_style),
    .mask   (ram_mask),
    .offset (ram_offset),
    .hit    (ram_hit)
  );

  assign add_en = acc_valid && !dma_active;
  assign ram_we = acc_valid && acc_write && ram_hit && (ram_mask != '0);

  brt_cycle_accum #(.ACC_W(ACC_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .add_en    (add_en),
    .cost      (acc_cost),
    .threshold (next_event),
    .thr_adv   (event_adv),
    .count     (cycle_count),
    .due       (event_due)
  );

  always_comb begin
    dirty_d = ram_dirty;
    if (ram_we) begin
      dirty_d = 1'b1;
    end else if (dirty_clr) begin
      dirty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ram_dirty <= 1'b0;
    end else begin
      ram_dirty <= dirty_d;
    end
  end
endmodule

// File: rtl/bus_region_timer_chk.sv
module bus_region_timer_chk #(
  parameter int RAM_AW = 20,
  parameter int ACC_W  = 16
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [23:0]       acc_addr,
  input logic              dma_active,
  input logic              fast_rom_en,
  input logic [RAM_AW-1:0] ram_mask,
  input logic [ACC_W-1:0]  next_event,
  input logic              event_adv,
  input logic [3:0]        acc_cost,
  input logic              ram_hit,
  input logic              ram_we,
  input logic              ram_dirty,
  input logic [ACC_W-1:0]  cycle_count,
  input logic              event_due
);
  assert_fast_upper_rom_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_addr[23] && acc_addr[15] && fast_rom_en) |-> acc_cost == 4'd6);

  assert_cost_legal_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_cost == 4'd6) || (acc_cost == 4'd8) || (acc_cost == 4'd12));

  assert_we_needs_ram_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    ram_we |-> (ram_hit && acc_write && (ram_mask != '0)));

  assert_dirty_follows_we_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    ram_we |=> ram_dirty);

  assert_count_adds_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_valid && !dma_active) |=> cycle_count == $past(cycle_count) + ACC_W'($past(acc_cost)));

  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (dma_active || !acc_valid) |=> $stable(cycle_count));

  assert_event_clear_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    event_adv |=> !event_due);

  assert_event_set_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!event_adv && cycle_count >= next_event) |=> event_due);
endmodule

bind bus_region_timer bus_region_timer_chk #(.RAM_AW(RAM_AW), .ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_addr    (acc_addr),
  .dma_active  (dma_active),
  .fast_rom_en (fast_rom_en),
  .ram_mask    (ram_mask),
  .next_event  (next_event),
  .event_adv   (event_adv),
  .acc_cost    (acc_cost),
  .ram_hit     (ram_hit),
  .ram_we      (ram_we),
  .ram_dirty   (ram_dirty),
  .cycle_count (cycle_count),
  .event_due   (event_due)
);

// File: tb/bus_region_timer_bench.sv
module bus_region_timer_bench;
  localparam int RAM_AW = 20;
  localparam int ACC_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              acc_valid;
  logic              acc_write;
  logic [23:0]       acc_addr;
  logic              dma_active;
  logic              fast_rom_en;
  logic              ram_style;
  logic [RAM_AW-1:0] ram_mask;
  logic [ACC_W-1:0]  next_event;
  logic              event_adv;
  logic              dirty_clr;
  logic [3:0]        acc_cost;
  logic              rom_class;
  logic              ram_hit;
  logic [RAM_AW-1:0] ram_offset;
  logic              ram_we;
  logic              ram_dirty;
  logic [ACC_W-1:0]  cycle_count;
  logic              event_due;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bus_region_timer #(.RAM_AW(RAM_AW), .ACC_W(ACC_W)) u_bus_region_timer (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic cost_at(input string req, input logic [23:0] a, input logic fe,
                         input logic [3:0] exp_cost, input logic exp_rom);
    @(negedge clk);
    acc_addr = a; fast_rom_en = fe; acc_valid = 1'b0;
    #1;
    chk(req, {28'd0, acc_cost}, {28'd0, exp_cost});
    chk(req, {31'd0, rom_class}, {31'd0, exp_rom});
  endtask

  task automatic test_reset();
    chk("R10 count", {16'd0, cycle_count}, 32'd0);
    chk("R10 dirty", {31'd0, ram_dirty}, 32'd0);
    chk("R10 event", {31'd0, event_due}, 32'd0);
  endtask

  task automatic test_costs();
    cost_at("R1 fast upper rom", 24'h808000, 1'b1, 4'd6, 1'b1);
    cost_at("R1 upper rom no fast", 24'h808000, 1'b0, 4'd8, 1'b1);
    cost_at("R1 lower rom", 24'h008000, 1'b1, 4'd8, 1'b1);
    cost_at("R1 bit22 bank", 24'h400000, 1'b1, 4'd8, 1'b1);
    cost_at("R2 low page", 24'h000000, 1'b0, 4'd8, 1'b0);
    cost_at("R2 6000 area", 24'h006000, 1'b0, 4'd8, 1'b0);
    cost_at("R3 2100 fast", 24'h002100, 1'b0, 4'd6, 1'b0);
    cost_at("R3 4200 fast", 24'h004200, 1'b0, 4'd6, 1'b0);
    cost_at("R3 4016 xslow", 24'h004016, 1'b0, 4'd12, 1'b0);
  endtask

  task automatic test_fold();
    @(negedge clk);
    ram_style = 1'b0; ram_mask = 20'h0FFFF; acc_addr = 24'h711234; #1;
    chk("R4 low offset", {12'd0, ram_offset}, 32'h9234);
    chk("R4 low hit", {31'd0, ram_hit}, 32'd1);
    acc_addr = 24'h7E1234; #1;
    chk("R4 low miss wram bank", {31'd0, ram_hit}, 32'd0);
    acc_addr = 24'h709234; #1;
    chk("R4 low miss upper half", {31'd0, ram_hit}, 32'd0);
    ram_style = 1'b1; ram_mask = 20'h0FFFF; acc_addr = 24'h316005; #1;
    chk("R5 high offset", {12'd0, ram_offset}, 32'h2005);
    chk("R5 high hit", {31'd0, ram_hit}, 32'd1);
    ram_mask = 20'h01FFF; #1;
    chk("R5 high masked", {12'd0, ram_offset}, 32'h0005);
    acc_addr = 24'h208000; #1;
    chk("R5 high miss", {31'd0, ram_hit}, 32'd0);
  endtask

  task automatic test_write();
    @(negedge clk);
    ram_style = 1'b1; acc_addr = 24'h206010; ram_mask = '0;
    acc_valid = 1'b1; acc_write = 1'b1; dma_active = 1'b1; #1;
    chk("R6 no ram we", {31'd0, ram_we}, 32'd0);
    @(negedge clk);
    chk("R6 no ram dirty", {31'd0, ram_dirty}, 32'd0);
    acc_write = 1'b0; ram_mask = 20'h01FFF; #1;
    chk("R6 read no we", {31'd0, ram_we}, 32'd0);
    acc_write = 1'b1; acc_addr = 24'h208000; #1;
    chk("R6 outside no we", {31'd0, ram_we}, 32'd0);
    @(negedge clk);
    chk("R6 outside no dirty", {31'd0, ram_dirty}, 32'd0);
    acc_addr = 24'h206010; #1;
    chk("R6 accepted we", {31'd0, ram_we}, 32'd1);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    chk("R7 dirty set", {31'd0, ram_dirty}, 32'd1);
    @(negedge clk);
    chk("R7 dirty sticky", {31'd0, ram_dirty}, 32'd1);
    dirty_clr = 1'b1;
    @(negedge clk);
    dirty_clr = 1'b0;
    chk("R7 dirty cleared", {31'd0, ram_dirty}, 32'd0);
    dma_active = 1'b0;
  endtask

  task automatic test_accum();
    logic [15:0] base;
    @(negedge clk);
    base = cycle_count;
    chk("R8 idle hold", {16'd0, base}, 32'd0);
    acc_addr = 24'h002100; fast_rom_en = 1'b0; acc_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 three fast", {16'd0, cycle_count}, 32'd18);
    dma_active = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 dma hold", {16'd0, cycle_count}, 32'd18);
    dma_active = 1'b0; acc_addr = 24'h004016;
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R8 xslow add", {16'd0, cycle_count}, 32'd30);
  endtask

  task automatic test_event();
    chk("R9 below threshold", {31'd0, event_due}, 32'd0);
    next_event = 16'd30; event_adv = 1'b1;
    @(negedge clk);
    event_adv = 1'b0;
    chk("R9 clear priority", {31'd0, event_due}, 32'd0);
    @(negedge clk);
    chk("R9 reached", {31'd0, event_due}, 32'd1);
    @(negedge clk);
    chk("R9 held", {31'd0, event_due}, 32'd1);
    next_event = 16'd200; event_adv = 1'b1;
    @(negedge clk);
    event_adv = 1'b0;
    chk("R9 advanced", {31'd0, event_due}, 32'd0);
    @(negedge clk);
    chk("R9 stays low", {31'd0, event_due}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    dma_active = 1'b0; fast_rom_en = 1'b0; ram_style = 1'b0; ram_mask = '0;
    next_event = 16'd100; event_adv = 1'b0; dirty_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_costs();
    test_fold();
    test_write();
    test_accum();
    test_event();
    finish_run();
  end
endmodule